// File: doc/BRIEF.md
# Upper Memory Shadow and SMRAM Route Decoder

This block decides, for every memory access in the upper part of the first megabyte, whether the access is served by internal DRAM or forwarded to the external bus. The window from 0xC0000 to 0xFFFFF is split into twelve 16 KB regions followed by one 64 KB region at the top. Each region carries two independent enables, one for reads and one for writes, so firmware can, for example, copy a ROM image into DRAM by reading externally and writing internally, and then lock it down by reading internally and writing externally.

Four configuration bytes hold the enables. They are loaded through a small byte-write port and reset to zero, so every region starts on the external bus. The last byte also carries the enable for the 128 KB system-management area at 0xA0000. While the system-management mode input is high, that area always routes to DRAM. Two status outputs report whether any region in the top 128 KB (0xE0000 and up) has internal reads or internal writes enabled.

The decode from an access address to a route is combinational. Only the configuration bytes are registered, and a byte write takes effect on the clock edge that accepts it.

Top module: `umem_shadow_decoder`

## Requirements
- R1: After reset all four configuration bytes read back as 0x00, every access reports an external route with no SMRAM hit, and both BIOS shadow flags are 0.
- R2: Configuration byte r (r = 0, 1, 2) bit 2p (p = 0..3) set routes writes to the 16 KB region starting at 0xC0000 + 0x4000*(4r+p) to DRAM (route_int_o = 1). With the bit clear, writes there go external. Reads are unaffected by this bit.
- R3: Configuration byte r bit 2p+1 set routes reads from that same 16 KB region to DRAM. Writes are unaffected by this bit.
- R4: Configuration byte 3 bit 0 routes writes, and bit 1 routes reads, for the whole 64 KB region 0xF0000 to 0xFFFFF.
- R5: bios_wr_shadow_o is 1 exactly when at least one of byte 2 bits 0, 2, 4, 6 or byte 3 bit 0 is set.
- R6: bios_rd_shadow_o is 1 exactly when at least one of byte 2 bits 1, 3, 5, 7 or byte 3 bit 1 is set.
- R7: A write to configuration byte 3 stores the data ANDed with 0xE3, so bits 4:2 read back as 0. Bytes 0 to 2 store all eight bits. cfg_rdata_o shows the byte chosen by cfg_sel_i.
- R8: Outside system-management mode, an access in 0xA0000 to 0xBFFFF gives smram_hit_o = 1 and route_int_o = 1 when byte 3 bit 7 is set, and external with no hit when that bit is clear.
- R9: With smm_i = 1, every access in 0xA0000 to 0xBFFFF gives smram_hit_o = 1 and route_int_o = 1, whatever the value of byte 3 bit 7.
- R10: Addresses below 0xA0000 always report an external route and no SMRAM hit, whatever the configuration.
- R11: A configuration write and an access in the same cycle decode that access with the configuration held before the clock edge. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_sel_i | input | 2 | Configuration byte index for writes and readback |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Selected configuration byte |
| acc_addr_i | input | 20 | Access address |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| smm_i | input | 1 | System-management mode active |
| route_int_o | output | 1 | 1 = access served by internal DRAM, 0 = external bus |
| smram_hit_o | output | 1 | Access falls in the enabled SMRAM area |
| bios_rd_shadow_o | output | 1 | Internal reads enabled somewhere at or above 0xE0000 |
| bios_wr_shadow_o | output | 1 | Internal writes enabled somewhere at or above 0xE0000 |

## Verification
Two things can happen in the same cycle: a configuration byte write and the combinational decode of an access. The bench provokes this by presenting an access to a region while the byte that controls that region is being written. It expects the route from the old configuration in that cycle, then probes the same address in the next cycle and expects the route from the new value. Sampling happens just before the accepting clock edge, so a decode that already uses the new data is reported.

// File: rtl/umem_pkg.sv
package umem_pkg;
  localparam int ADDR_W      = 20;
  localparam int CFG_BYTES   = 4;
  localparam int SEL_W       = $clog2(CFG_BYTES);
  localparam int PAIRS       = 4;
  localparam int SMALL_CNT   = (CFG_BYTES - 1) * PAIRS;
  localparam int SMALL_SHIFT = 14;
  localparam int BIG_SHIFT   = 16;
  localparam int SMRAM_SHIFT = 17;
  localparam int SMALL_BASE  = 'hC0000 >> SMALL_SHIFT;
  localparam int BIG_TAG     = 'hF0000 >> BIG_SHIFT;
  localparam int SMRAM_TAG   = 'hA0000 >> SMRAM_SHIFT;
  localparam int BIOS_FIRST  = ('hE0000 - 'hC0000) >> SMALL_SHIFT;
  localparam logic [7:0] LAST_MASK = 8'hE3;
  localparam int SMRAM_EN_BIT = 7;

  typedef logic [CFG_BYTES-1:0][7:0] cfg_t;
endpackage

// File: rtl/umem_cfg_regs.sv
module umem_cfg_regs
  import umem_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [7:0]       wdata_i,
  output cfg_t             cfg_o,
  output logic [7:0]       rdata_o
);
  cfg_t cfg_q;

  for (genvar b = 0; b < CFG_BYTES; b++) begin : g_byte
    localparam logic [7:0] KEEP = (b == CFG_BYTES - 1) ? LAST_MASK : 8'hFF;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             cfg_q[b] <= '0;
      else if (we_i && sel_i == SEL_W'(b))     cfg_q[b] <= wdata_i & KEEP;
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = cfg_q[sel_i];
endmodule

// File: rtl/umem_region_map.sv
module umem_region_map
  import umem_pkg::*;
(
  input  cfg_t              cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  output logic              region_int_o,
  output logic              bios_rd_o,
  output logic              bios_wr_o
);
  localparam int N_REG = SMALL_CNT + 1;
  localparam int SW    = ADDR_W - SMALL_SHIFT;
  localparam int BW    = ADDR_W - BIG_SHIFT;

  logic [N_REG-1:0] hit, wr_en, rd_en;

  for (genvar k = 0; k < SMALL_CNT; k++) begin : g_small
    localparam logic [SW-1:0] TAG = SW'(SMALL_BASE + k);
    assign hit[k]   = (addr_i[ADDR_W-1:SMALL_SHIFT] == TAG);
    assign wr_en[k] = cfg_i[k / PAIRS][2 * (k % PAIRS)];
    assign rd_en[k] = cfg_i[k / PAIRS][2 * (k % PAIRS) + 1];
  end

  // single large region at the top, lowest pair of the last byte
  assign hit[SMALL_CNT]   = (addr_i[ADDR_W-1:BIG_SHIFT] == BW'(BIG_TAG));
  assign wr_en[SMALL_CNT] = cfg_i[CFG_BYTES-1][0];
  assign rd_en[SMALL_CNT] = cfg_i[CFG_BYTES-1][1];

  assign region_int_o = |(hit & (write_i ? wr_en : rd_en));
  assign bios_wr_o    = |wr_en[N_REG-1:BIOS_FIRST];
  assign bios_rd_o    = |rd_en[N_REG-1:BIOS_FIRST];

  logic unused_inputs;
  assign unused_inputs = ^{addr_i[SMALL_SHIFT-1:0], cfg_i[CFG_BYTES-1][7:2]};
endmodule

// File: rtl/umem_smram_sel.sv
module umem_smram_sel
  import umem_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              smm_i,
  input  logic              open_i,
  output logic              hit_o
);
  localparam int TW = ADDR_W - SMRAM_SHIFT;

  logic in_area;
  assign in_area = (addr_i[ADDR_W-1:SMRAM_SHIFT] == TW'(SMRAM_TAG));
  assign hit_o   = in_area && (smm_i || open_i);

  logic unused_addr;
  assign unused_addr = ^addr_i[SMRAM_SHIFT-1:0];
endmodule

// File: rtl/umem_shadow_decoder.sv
module umem_shadow_decoder
  import umem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic [19:0]       acc_addr_i,
  input  logic              acc_write_i,
  input  logic              smm_i,
  output logic              route_int_o,
  output logic              smram_hit_o,
  output logic              bios_rd_shadow_o,
  output logic              bios_wr_shadow_o
);
  cfg_t cfg;
  logic region_int, smram_hit;

  umem_cfg_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  umem_region_map u_map (
    .cfg_i        (cfg),
    .addr_i       (acc_addr_i),
    .write_i      (acc_write_i),
    .region_int_o (region_int),
    .bios_rd_o    (bios_rd_shadow_o),
    .bios_wr_o    (bios_wr_shadow_o)
  );

  umem_smram_sel u_smram (
    .addr_i (acc_addr_i),
    .smm_i  (smm_i),
    .open_i (cfg[CFG_BYTES-1][SMRAM_EN_BIT]),
    .hit_o  (smram_hit)
  );

  assign smram_hit_o = smram_hit;
  assign route_int_o = smram_hit | region_int;
endmodule

// File: rtl/umem_checker.sv
module umem_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [1:0]  cfg_sel_i,
  input logic [7:0]  cfg_wdata_i,
  input logic [7:0]  last_cfg_i,
  input logic [19:0] acc_addr_i,
  input logic        acc_write_i,
  input logic        smm_i,
  input logic        route_int_o,
  input logic        smram_hit_o,
  input logic        bios_rd_shadow_o,
  input logic        bios_wr_shadow_o
);
  logic in_smram;
  assign in_smram = (acc_addr_i[19:17] == 3'b101);

  assert_low_external_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_addr_i < 20'hA0000) |-> (!route_int_o && !smram_hit_o));

  assert_smm_forces_dram_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smm_i && in_smram) |-> (smram_hit_o && route_int_o));

  assert_smram_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smram_hit_o |-> (in_smram && route_int_o));

  assert_last_byte_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i == 2'd3) |=> (last_cfg_i == ($past(cfg_wdata_i) & 8'hE3)));

  assert_bios_wr_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_int_o && acc_write_i && acc_addr_i >= 20'hE0000) |-> bios_wr_shadow_o);

  assert_bios_rd_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_int_o && !acc_write_i && acc_addr_i >= 20'hE0000) |-> bios_rd_shadow_o);
endmodule

bind umem_shadow_decoder umem_checker u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cfg_we_i         (cfg_we_i),
  .cfg_sel_i        (cfg_sel_i),
  .cfg_wdata_i      (cfg_wdata_i),
  .last_cfg_i       (cfg[3]),
  .acc_addr_i       (acc_addr_i),
  .acc_write_i      (acc_write_i),
  .smm_i            (smm_i),
  .route_int_o      (route_int_o),
  .smram_hit_o      (smram_hit_o),
  .bios_rd_shadow_o (bios_rd_shadow_o),
  .bios_wr_shadow_o (bios_wr_shadow_o)
);

// File: tb/sim_umem_shadow_decoder.sv
module sim_umem_shadow_decoder;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic [19:0] addr = '0;
  logic wr = 1'b0, smm = 1'b0;
  logic route, hit, brd, bwr;

  always #10 clk = ~clk;

  umem_shadow_decoder u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .acc_addr_i(addr),
    .acc_write_i(wr), .smm_i(smm), .route_int_o(route), .smram_hit_o(hit),
    .bios_rd_shadow_o(brd), .bios_wr_shadow_o(bwr)
  );

  typedef struct {
    logic [11:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  logic [7:0] m [4];
  int checks = 0, errors = 0;
  bit done = 0;

  // expected {rdata, route, hit, brd, bwr}
  function automatic logic [11:0] model(logic [19:0] a, logic w, logic s, logic [1:0] sel);
    logic h, en, r, b_rd, b_wr;
    logic [1:0] bits;
    h = (a[19:17] == 3'b101) && (s || m[3][7]);
    bits = 2'b00;
    if (a[19:16] == 4'hF)       bits = m[3][1:0];
    else if (a[19:18] == 2'b11) bits = m[a[17:16]][2*a[15:14] +: 2];
    en = w ? bits[0] : bits[1];
    r = h | en;
    b_wr = m[3][0] | m[2][0] | m[2][2] | m[2][4] | m[2][6];
    b_rd = m[3][1] | m[2][1] | m[2][3] | m[2][5] | m[2][7];
    return {m[sel], r, h, b_rd, b_wr};
  endfunction

  task automatic push(logic [19:0] a, logic w, logic s, string tag);
    item_t it;
    addr = a; wr = w; smm = s;
    it.exp = model(a, w, s, cfg_sel);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic probe(logic [19:0] a, logic w, logic s, logic [1:0] sel, string tag);
    @(negedge clk);
    cfg_sel = sel;
    push(a, w, s, tag);
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [7:0] d, bit with_probe,
                           logic [19:0] a, logic w, string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    if (with_probe) push(a, w, 1'b0, tag);
    @(posedge clk);
    m[sel] = (sel == 2'd3) ? (d & 8'hE3) : d;
    #1 cfg_we = 1'b0;
  endtask

  // monitor: compare just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #8;
      while (q.size() > 0) begin
        item_t it;
        logic [11:0] act;
        it = q.pop_front();
        act = {cfg_rdata, route, hit, brd, bwr};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: got rdata=%h route=%b hit=%b brd=%b bwr=%b, expected rdata=%h route=%b hit=%b brd=%b bwr=%b",
                   it.tag, act[11:4], act[3], act[2], act[1], act[0],
                   it.exp[11:4], it.exp[3], it.exp[2], it.exp[1], it.exp[0]);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int s = 0; s < 4; s++) probe(20'hC0000 + 20'(s) * 20'h10000, 1'b1, 1'b0, 2'(s), "R1 reset");
    probe(20'hA0000, 1'b0, 1'b0, 2'd3, "R1 reset smram");
    probe(20'hFFFF0, 1'b0, 1'b0, 2'd0, "R1 reset top");

    // R2 write enable, byte0 pair0
    cfg_write(2'd0, 8'h01, 0, '0, 0, "");
    probe(20'hC0000, 1'b1, 1'b0, 2'd0, "R2 write int");
    probe(20'hC3FFF, 1'b0, 1'b0, 2'd0, "R2 read stays ext");
    probe(20'hC4000, 1'b1, 1'b0, 2'd0, "R2 neighbour ext");
    // R2 byte1 pair2 -> 0xD8000
    cfg_write(2'd1, 8'h10, 0, '0, 0, "");
    probe(20'hD8000, 1'b1, 1'b0, 2'd1, "R2 byte1 pair2");
    probe(20'hDBFFF, 1'b1, 1'b0, 2'd1, "R2 byte1 pair2 end");
    probe(20'hDC000, 1'b1, 1'b0, 2'd1, "R2 byte1 pair3 ext");

    // R3 and R6: byte2 pair3 read
    cfg_write(2'd2, 8'h80, 0, '0, 0, "");
    probe(20'hEC000, 1'b0, 1'b0, 2'd2, "R3 read int R6");
    probe(20'hEFFFF, 1'b1, 1'b0, 2'd2, "R3 write stays ext");
    probe(20'hE8000, 1'b0, 1'b0, 2'd2, "R3 other pair ext");

    // R4 and R5: top 64K region writes
    cfg_write(2'd3, 8'h01, 0, '0, 0, "");
    probe(20'hF0000, 1'b1, 1'b0, 2'd3, "R4 write int R5");
    probe(20'hFFFFF, 1'b1, 1'b0, 2'd3, "R4 write end");
    probe(20'hF8000, 1'b0, 1'b0, 2'd3, "R4 read ext");
    cfg_write(2'd3, 8'h02, 0, '0, 0, "");
    probe(20'hF4000, 1'b0, 1'b0, 2'd3, "R4 read int");

    // R5: byte2 write bit alone
    cfg_write(2'd2, 8'h04, 0, '0, 0, "");
    probe(20'hE4000, 1'b1, 1'b0, 2'd2, "R5 byte2 wr flag");

    // R7 masking and full-width bytes
    cfg_write(2'd3, 8'hFF, 0, '0, 0, "");
    probe(20'h00000, 1'b0, 1'b0, 2'd3, "R7 mask E3");
    cfg_write(2'd1, 8'hFF, 0, '0, 0, "");
    probe(20'h00000, 1'b0, 1'b0, 2'd1, "R7 byte1 full");

    // R10 below the window, everything enabled
    cfg_write(2'd0, 8'hFF, 0, '0, 0, "");
    cfg_write(2'd2, 8'hFF, 0, '0, 0, "");
    probe(20'h9FFFF, 1'b1, 1'b1, 2'd0, "R10 below smram");
    probe(20'h00000, 1'b0, 1'b1, 2'd0, "R10 zero");

    // R8 smram enable outside smm
    probe(20'hA0000, 1'b0, 1'b0, 2'd3, "R8 enabled");
    probe(20'hBFFFF, 1'b1, 1'b0, 2'd3, "R8 enabled end");
    cfg_write(2'd3, 8'h00, 0, '0, 0, "");
    probe(20'hB0000, 1'b0, 1'b0, 2'd3, "R8 disabled");

    // R9 smm forces dram
    probe(20'hB0000, 1'b0, 1'b1, 2'd3, "R9 smm read");
    probe(20'hA8000, 1'b1, 1'b1, 2'd3, "R9 smm write");
    probe(20'hC0000, 1'b1, 1'b1, 2'd3, "R9 smm outside area");

    // R11 write and access in the same cycle
    cfg_write(2'd0, 8'h00, 0, '0, 0, "");
    cfg_write(2'd0, 8'h02, 1, 20'hC0000, 1'b0, "R11 old value");
    probe(20'hC0000, 1'b0, 1'b0, 2'd0, "R11 new value");
    cfg_write(2'd3, 8'h80, 1, 20'hA0000, 1'b0, "R11 smram old");
    probe(20'hA0000, 1'b0, 1'b0, 2'd3, "R11 smram new");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule